// File: doc/BRIEF.md
# Coherence Acknowledgment Collector

This block sits beside one outstanding miss entry at a home node. While the entry is collecting, the home has sent interventions or invalidations to remote private caches. Each remote cache answers with its own line state. The collector holds two bit vectors per side, with one bit per CPU in each. The sides are instruction and data. One vector marks requests that have been sent. The other marks acknowledgments that have been accepted. The collector judges every answer against the state the home copy holds, for the kind of request that was sent. An acceptable answer sets the ack bit. An unacceptable one clears the sent bit, so the home logic reissues the request to that CPU.

The same response path serves an entry that is waiting for line data from a remote node. When a matching acknowledgment arrives in that phase, the collector loads the refill beat counter and pulses a request to move the entry to the replace phase. The collector also raises a one-cycle dirty pulse whenever a remote cache reports that its copy was modified. It reports when every sent request has a matching ack on the same side.

Top module: `coh_ack_collector`

## Requirements
- R1: After reset, all four vectors are zero, `all_acked` is 1, `dirty_set` and `go_replace` are 0, and `beat_cnt` is 0.
- R2: `iss_valid` sets the sent bit of CPU `iss_cpu`, on the instruction side when `iss_instr` is 1 and on the data side otherwise. `clr` zeroes all vectors and `beat_cnt`.
- R3: Line states are encoded INVALID=0, SHARED=1, EXCLUSIVE=2, MODIFIED=3. For a shared intervention (`ivn_kind`=0), a report of EXCLUSIVE or MODIFIED sets the CPU's data ack bit. Any other report clears its data sent bit. The instruction flag does not matter for this kind.
- R4: For an exclusive intervention (`ivn_kind`=1), a report is accepted when it equals `home_state`, or when `home_state` is EXCLUSIVE and the report is MODIFIED. Otherwise the sent bit is cleared.
- R5: For an invalidate (`ivn_kind`=2), a report is accepted only when it equals `home_state`. Otherwise the sent bit is cleared. Kind 3 leaves the vectors unchanged.
- R6: For kinds 1 and 2, acceptance and rejection act on the instruction side when `rsp_instr` is 1 and on the data side otherwise. The other side is left unchanged.
- R7: A matching acknowledgment that reports MODIFIED while `ent_phase` is collecting (1) raises `dirty_set` for exactly one cycle, whether or not it is accepted.
- R8: A response counts only when `rsp_addr` equals `ent_addr` once the low log2(`LINE_BYTES`) offset bits are ignored. A response that differs above those bits changes nothing.
- R9: Response kinds are ACK=0, ACK_DATA=1, NACK=2, reserved=3. Kinds 2 and 3 change nothing. Responses also change nothing while `ent_phase` is idle (0) or replace (3).
- R10: In phase waiting-for-refill (2), a matching ACK or ACK_DATA pulses `go_replace` for one cycle and loads `beat_cnt` with 4. The vectors are left unchanged.
- R11: `all_acked` is 1 exactly when every sent bit has the ack bit of the same CPU and side set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start of a new entry: clears vectors and beat count |
| ivn_kind | input | 2 | Kind of request sent to remote caches |
| ent_phase | input | 2 | Current phase of the miss entry |
| ent_addr | input | ADDR_W | Block address of the entry |
| home_state | input | 2 | State of the home copy |
| iss_valid | input | 1 | A request is being sent to a CPU |
| iss_cpu | input | CPU_W | CPU receiving the request |
| iss_instr | input | 1 | Request targets the instruction side |
| rsp_valid | input | 1 | A response is present |
| rsp_kind | input | 2 | Response kind |
| rsp_state | input | 2 | Line state reported by the responder |
| rsp_cpu | input | CPU_W | Responding CPU |
| rsp_instr | input | 1 | Response concerns the instruction side |
| rsp_addr | input | ADDR_W | Block address carried by the response |
| instr_sent | output | NCPU | Instruction-side sent bits |
| instr_ack | output | NCPU | Instruction-side ack bits |
| data_sent | output | NCPU | Data-side sent bits |
| data_ack | output | NCPU | Data-side ack bits |
| all_acked | output | 1 | Every sent bit has its matching ack |
| dirty_set | output | 1 | One-cycle pulse: the home copy must be marked dirty |
| go_replace | output | 1 | One-cycle pulse: the entry moves to the replace phase |
| beat_cnt | output | 3 | Refill beat counter |

## Verification
Every registered result reacts to a response or issue at the next rising edge. This covers the vector bits, `dirty_set`, `go_replace` and `beat_cnt`. `all_acked` is decoded from the vectors, so it follows one edge after the update as well. The bench changes inputs on the falling edge and lets exactly one rising edge pass. It then samples on the following falling edge, inside the single cycle in which a pulse is high. For each pulse it takes one more step and checks that the pulse has dropped.

// File: rtl/cohack_pkg.sv
package cohack_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        IV_SHARED = 2'd0,
        IV_EXCL   = 2'd1,
        IV_KILL   = 2'd2,
        IV_RSVD   = 2'd3
    } ivn_kind_e;

    typedef enum logic [1:0] {
        RK_ACK  = 2'd0,
        RK_ACKD = 2'd1,
        RK_NACK = 2'd2,
        RK_RSVD = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_COLLECT   = 2'd1,
        PH_WAIT_FILL = 2'd2,
        PH_REPLACE   = 2'd3
    } entry_phase_e;

    localparam int unsigned FILL_BEATS = 4;
    localparam int unsigned BEAT_W     = $clog2(FILL_BEATS + 1);

    // Outcome of judging one response against the home copy.
    typedef struct packed {
        logic known;       // request kind is defined
        logic accept;      // response counts as an ack
        logic instr_side;  // update targets the instruction side
    } verdict_t;

    function automatic logic is_ack_kind(rsp_kind_e k);
        return (k == RK_ACK) || (k == RK_ACKD);
    endfunction

endpackage

// File: rtl/cohack_judge.sv
module cohack_judge
    import cohack_pkg::*;
(
    input  ivn_kind_e   kind,
    input  line_state_e rpt,
    input  line_state_e home,
    input  logic        instr,
    output verdict_t    verdict
);

    always_comb begin
        verdict = '0;
        case (kind)
            IV_SHARED: begin
                verdict.known      = 1'b1;
                verdict.accept     = (rpt == ST_EXC) || (rpt == ST_MOD);
                verdict.instr_side = 1'b0;
            end
            IV_EXCL: begin
                verdict.known      = 1'b1;
                verdict.accept     = (rpt == home) ||
                                     ((home == ST_EXC) && (rpt == ST_MOD));
                verdict.instr_side = instr;
            end
            IV_KILL: begin
                verdict.known      = 1'b1;
                verdict.accept     = (rpt == home);
                verdict.instr_side = instr;
            end
            default: verdict = '0;
        endcase
    end

endmodule

// File: rtl/cohack_vectors.sv
module cohack_vectors #(
    parameter int unsigned NCPU  = 8,
    parameter int unsigned CPU_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    iss_valid,
    input  logic [CPU_W-1:0]        iss_cpu,
    input  logic                    iss_instr,
    input  logic                    upd_valid,
    input  logic [CPU_W-1:0]        upd_cpu,
    input  logic                    upd_instr,
    input  logic                    upd_accept,
    output logic [1:0][NCPU-1:0]    sent,
    output logic [1:0][NCPU-1:0]    acked
);

    // side index 1 = instruction, 0 = data
    for (genvar s = 0; s < 2; s++) begin : g_side
        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            logic iss_here;
            logic upd_here;

            assign iss_here = iss_valid && (iss_cpu == CPU_W'(c)) && (iss_instr == 1'(s));
            assign upd_here = upd_valid && (upd_cpu == CPU_W'(c)) && (upd_instr == 1'(s));

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    sent[s][c]  <= 1'b0;
                    acked[s][c] <= 1'b0;
                end else begin
                    if (upd_here && !upd_accept)
                        sent[s][c] <= 1'b0;
                    else if (iss_here)
                        sent[s][c] <= 1'b1;
                    if (upd_here && upd_accept)
                        acked[s][c] <= 1'b1;
                end
            end

            // R3 R4 R5
            ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(acked[s][c]) |-> $past(upd_valid && upd_accept &&
                    (upd_cpu == CPU_W'(c)) && (upd_instr == 1'(s))));

            // R2 R6
            sent_fall_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(sent[s][c]) |-> $past(clr || (upd_valid && !upd_accept &&
                    (upd_cpu == CPU_W'(c)) && (upd_instr == 1'(s)))));
        end
    end

endmodule

// File: rtl/cohack_fill.sv
module cohack_fill
    import cohack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fill_hit,
    output logic [BEAT_W-1:0] beats,
    output logic              go_replace
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beats      <= '0;
            go_replace <= 1'b0;
        end else begin
            go_replace <= fill_hit;
            if (fill_hit)
                beats <= BEAT_W'(FILL_BEATS);
            else if (clr)
                beats <= '0;
        end
    end

    // R10
    beats_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fill_hit) |-> (beats == BEAT_W'(FILL_BEATS)) && go_replace);

endmodule

// File: rtl/coh_ack_collector.sv
module coh_ack_collector
    import cohack_pkg::*;
#(
    parameter int unsigned NCPU       = 8,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 32,
    localparam int unsigned CPU_W     = $clog2(NCPU),
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [1:0]        ivn_kind,
    input  logic [1:0]        ent_phase,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [1:0]        home_state,
    input  logic              iss_valid,
    input  logic [CPU_W-1:0]  iss_cpu,
    input  logic              iss_instr,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [1:0]        rsp_state,
    input  logic [CPU_W-1:0]  rsp_cpu,
    input  logic              rsp_instr,
    input  logic [ADDR_W-1:0] rsp_addr,
    output logic [NCPU-1:0]   instr_sent,
    output logic [NCPU-1:0]   instr_ack,
    output logic [NCPU-1:0]   data_sent,
    output logic [NCPU-1:0]   data_ack,
    output logic              all_acked,
    output logic              dirty_set,
    output logic [BEAT_W-1:0] beat_cnt,
    output logic              go_replace
);

    entry_phase_e phase;
    line_state_e  rpt_st;
    verdict_t     verdict;
    logic         line_hit;
    logic         rsp_hit;
    logic         collect_hit;
    logic         fill_hit;
    logic [1:0][NCPU-1:0] sent_v;
    logic [1:0][NCPU-1:0] ack_v;

    assign phase  = entry_phase_e'(ent_phase);
    assign rpt_st = line_state_e'(rsp_state);

    // Line match ignores the byte-offset bits.
    assign line_hit    = (rsp_addr >> OFF_W) == (ent_addr >> OFF_W);
    assign rsp_hit     = rsp_valid && is_ack_kind(rsp_kind_e'(rsp_kind)) && line_hit;
    assign collect_hit = rsp_hit && (phase == PH_COLLECT);
    assign fill_hit    = rsp_hit && (phase == PH_WAIT_FILL);

    cohack_judge u_judge (
        .kind    (ivn_kind_e'(ivn_kind)),
        .rpt     (rpt_st),
        .home    (line_state_e'(home_state)),
        .instr   (rsp_instr),
        .verdict (verdict)
    );

    cohack_vectors #(
        .NCPU  (NCPU),
        .CPU_W (CPU_W)
    ) u_vec (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .iss_valid  (iss_valid),
        .iss_cpu    (iss_cpu),
        .iss_instr  (iss_instr),
        .upd_valid  (collect_hit && verdict.known),
        .upd_cpu    (rsp_cpu),
        .upd_instr  (verdict.instr_side),
        .upd_accept (verdict.accept),
        .sent       (sent_v),
        .acked      (ack_v)
    );

    cohack_fill u_fill (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .fill_hit   (fill_hit),
        .beats      (beat_cnt),
        .go_replace (go_replace)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dirty_set <= 1'b0;
        else
            dirty_set <= collect_hit && verdict.known && (rpt_st == ST_MOD);
    end

    assign instr_sent = sent_v[1];
    assign instr_ack  = ack_v[1];
    assign data_sent  = sent_v[0];
    assign data_ack   = ack_v[0];
    assign all_acked  = &(~sent_v[1] | ack_v[1]) & &(~sent_v[0] | ack_v[0]);

    // R7
    dirty_cause_chk: assert property (@(posedge clk) disable iff (rst)
        dirty_set |-> $past(rsp_valid) && ($past(rsp_state) == 2'd3) &&
                      ($past(ent_phase) == 2'd1));

    // R10
    replace_cause_chk: assert property (@(posedge clk) disable iff (rst)
        go_replace |-> $past(rsp_valid) && ($past(ent_phase) == 2'd2));

    // R9
    nack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rsp_valid || rsp_kind[1]) |-> !dirty_set && !go_replace);

    // R8
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rsp_addr >> OFF_W) != $past(ent_addr >> OFF_W)) && $past(!iss_valid && !clr)
            |-> $stable(instr_ack) && $stable(data_ack) && !dirty_set && !go_replace);

endmodule

// File: tb/coh_ack_collector_tb.sv
module coh_ack_collector_tb;

    localparam int NCPU = 8;
    localparam int AW   = 32;
    localparam logic [AW-1:0] ENT  = 32'h0000_1240;
    localparam logic [AW-1:0] NEAR = 32'h0000_125F;
    localparam logic [AW-1:0] FAR  = 32'h0000_1260;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic [1:0] ivn_kind = 2'd0;
    logic [1:0] ent_phase = 2'd0;
    logic [1:0] home_state = 2'd0;
    logic iss_valid = 1'b0;
    logic [2:0] iss_cpu = 3'd0;
    logic iss_instr = 1'b0;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_kind = 2'd0;
    logic [1:0] rsp_state = 2'd0;
    logic [2:0] rsp_cpu = 3'd0;
    logic rsp_instr = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [NCPU-1:0] instr_sent, instr_ack, data_sent, data_ack;
    logic all_acked, dirty_set, go_replace;
    logic [2:0] beat_cnt;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    coh_ack_collector u_dut (
        .clk(clk), .rst(rst), .clr(clr), .ivn_kind(ivn_kind), .ent_phase(ent_phase),
        .ent_addr(ENT), .home_state(home_state), .iss_valid(iss_valid),
        .iss_cpu(iss_cpu), .iss_instr(iss_instr), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_state(rsp_state), .rsp_cpu(rsp_cpu),
        .rsp_instr(rsp_instr), .rsp_addr(rsp_addr), .instr_sent(instr_sent),
        .instr_ack(instr_ack), .data_sent(data_sent), .data_ack(data_ack),
        .all_acked(all_acked), .dirty_set(dirty_set), .beat_cnt(beat_cnt),
        .go_replace(go_replace)
    );

    // fields: ivn[10:9] home[8:7] rpt[6:5] instr[4] cpu[3:1] accept[0]
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 2'd2, 2'd2, 1'b0, 3'd1, 1'b1},  // R3 shared, E reported
        {2'd0, 2'd2, 2'd3, 1'b1, 3'd2, 1'b1},  // R3 shared, M, instr flag ignored
        {2'd0, 2'd2, 2'd1, 1'b0, 3'd3, 1'b0},  // R3 shared, S reported
        {2'd0, 2'd2, 2'd0, 1'b1, 3'd4, 1'b0},  // R3 shared, I reported
        {2'd1, 2'd1, 2'd1, 1'b1, 3'd5, 1'b1},  // R4 exclusive, equal
        {2'd1, 2'd2, 2'd3, 1'b0, 3'd6, 1'b1},  // R4 exclusive, home E report M
        {2'd1, 2'd2, 2'd1, 1'b0, 3'd7, 1'b0},  // R4 exclusive, lower report
        {2'd1, 2'd1, 2'd2, 1'b1, 3'd0, 1'b0},  // R4 exclusive, home S report E
        {2'd2, 2'd1, 2'd1, 1'b0, 3'd1, 1'b1},  // R5 invalidate, equal
        {2'd2, 2'd1, 2'd0, 1'b1, 3'd2, 1'b0},  // R5 invalidate, I vs S
        {2'd2, 2'd2, 2'd2, 1'b0, 3'd3, 1'b1},  // R5 invalidate, E equal
        {2'd2, 2'd1, 2'd3, 1'b1, 3'd4, 1'b0}   // R5 invalidate, M vs S rejected
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic issue(input logic [2:0] cpu, input logic instr);
        iss_valid = 1'b1;
        iss_cpu   = cpu;
        iss_instr = instr;
        step();
        iss_valid = 1'b0;
    endtask

    task automatic respond(input logic [1:0] kind, input logic [1:0] st,
                           input logic [2:0] cpu, input logic instr,
                           input logic [AW-1:0] addr);
        rsp_valid = 1'b1;
        rsp_kind  = kind;
        rsp_state = st;
        rsp_cpu   = cpu;
        rsp_instr = instr;
        rsp_addr  = addr;
        step();
        rsp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;

        // R1 reset state
        chk("R1 instr_sent", int'(instr_sent), 0);
        chk("R1 data_ack", int'(data_ack), 0);
        chk("R1 all_acked", int'(all_acked), 1);
        chk("R1 pulses", int'({dirty_set, go_replace}), 0);
        chk("R1 beat_cnt", int'(beat_cnt), 0);

        // Table walk: R3 R4 R5 R6 R7
        ent_phase = 2'd1;
        for (int v = 0; v < NV; v++) begin
            logic [1:0] k, h, r;
            logic       fi, acc, isel;
            logic [2:0] c;
            {k, h, r, fi, c, acc} = VEC[v];
            isel = (k != 2'd0) && fi;
            ivn_kind   = k;
            home_state = h;
            do_clear();
            issue(c, 1'b0);
            issue(c, 1'b1);
            respond(2'd0, r, c, fi, ENT);
            if (isel) begin
                chk("R6 instr ack", int'(instr_ack[c]), int'(acc));
                chk("R6 instr sent", int'(instr_sent[c]), int'(acc));
                chk("R6 data untouched ack", int'(data_ack[c]), 0);
                chk("R6 data untouched sent", int'(data_sent[c]), 1);
            end else begin
                chk("R3 R4 R5 data ack", int'(data_ack[c]), int'(acc));
                chk("R3 R4 R5 data sent", int'(data_sent[c]), int'(acc));
                chk("R6 instr untouched ack", int'(instr_ack[c]), 0);
                chk("R6 instr untouched sent", int'(instr_sent[c]), 1);
            end
            chk("R7 dirty pulse", int'(dirty_set), int'(r == 2'd3));
        end
        step();
        chk("R7 dirty one cycle", int'(dirty_set), 0);

        // R2 clear and issue
        do_clear();
        chk("R2 clear", int'({instr_sent, data_sent, instr_ack, data_ack}), 0);
        issue(3'd5, 1'b1);
        chk("R2 issue instr", int'(instr_sent), 32);
        chk("R2 issue data idle", int'(data_sent), 0);

        // R8 line match
        do_clear();
        ivn_kind = 2'd0; home_state = 2'd2;
        issue(3'd2, 1'b0);
        respond(2'd0, 2'd2, 3'd2, 1'b0, FAR);
        chk("R8 far ack", int'(data_ack[2]), 0);
        chk("R8 far sent kept", int'(data_sent[2]), 1);
        respond(2'd0, 2'd3, 3'd2, 1'b0, FAR);
        chk("R8 far dirty", int'(dirty_set), 0);
        respond(2'd1, 2'd3, 3'd2, 1'b0, NEAR);
        chk("R8 offset ignored ack", int'(data_ack[2]), 1);
        chk("R7 dirty on M", int'(dirty_set), 1);

        // R9 ignored responses
        do_clear();
        issue(3'd4, 1'b0);
        respond(2'd2, 2'd1, 3'd4, 1'b0, ENT);
        chk("R9 nack sent kept", int'(data_sent[4]), 1);
        respond(2'd3, 2'd3, 3'd4, 1'b0, ENT);
        chk("R9 rsvd no dirty", int'(dirty_set), 0);
        chk("R9 rsvd no ack", int'(data_ack[4]), 0);
        ent_phase = 2'd0;
        respond(2'd0, 2'd2, 3'd4, 1'b0, ENT);
        chk("R9 idle no ack", int'(data_ack[4]), 0);
        ent_phase = 2'd3;
        respond(2'd0, 2'd1, 3'd4, 1'b0, ENT);
        chk("R9 replace sent kept", int'(data_sent[4]), 1);
        chk("R9 replace no pulse", int'(go_replace), 0);
        ent_phase = 2'd1;
        ivn_kind = 2'd3;
        respond(2'd0, 2'd1, 3'd4, 1'b0, ENT);
        chk("R5 rsvd kind sent kept", int'(data_sent[4]), 1);

        // R11 completion
        do_clear();
        ivn_kind = 2'd0; home_state = 2'd2;
        issue(3'd1, 1'b0);
        issue(3'd3, 1'b1);
        chk("R11 pending", int'(all_acked), 0);
        respond(2'd0, 2'd2, 3'd1, 1'b0, ENT);
        chk("R11 one left", int'(all_acked), 0);
        ivn_kind = 2'd1; home_state = 2'd1;
        respond(2'd0, 2'd1, 3'd3, 1'b1, ENT);
        chk("R11 instr ack", int'(instr_ack[3]), 1);
        chk("R11 done", int'(all_acked), 1);

        // R10 refill
        do_clear();
        issue(3'd0, 1'b0);
        ent_phase = 2'd2;
        respond(2'd0, 2'd2, 3'd0, 1'b0, FAR);
        chk("R10 far no pulse", int'(go_replace), 0);
        chk("R10 far beats", int'(beat_cnt), 0);
        respond(2'd1, 2'd2, 3'd0, 1'b0, ENT);
        chk("R10 pulse", int'(go_replace), 1);
        chk("R10 beats", int'(beat_cnt), 4);
        chk("R10 vectors kept", int'(data_ack[0]), 0);
        step();
        chk("R10 pulse one cycle", int'(go_replace), 0);
        chk("R10 beats held", int'(beat_cnt), 4);

        summary();
    end

endmodule